// File: doc/BRIEF.md
# BCD Real-Time Clock Core with Halt-and-Load Registers

This block keeps calendar time in packed BCD: seconds, minutes, hours in 24-hour form, day of week, day of month, month and two-digit year. A free-running oscillator enable is divided down to one count per second. Month lengths and leap years are handled in the rollover chain, and a year value divisible by four gives February 29 days.

Software reaches the clock through an eight-entry byte register port. Reads always come from a set of visible holding registers. While neither halt bit is set, these follow the running counters one cycle behind. Setting the load-halt bit freezes the visible set so that new values can be written into it. Clearing the bit copies all of them into the running counters in a single cycle and restarts the sub-second divider. Setting the read-halt bit also freezes the visible set, which gives a consistent snapshot, while the counters keep advancing underneath. An oscillator-stop flag in the seconds register halts the divider and the counters. It can be changed at any time, whatever the state of the halt bits.

Top module: `rtc_core`

## Requirements
- R1: After reset, the control register (offset 0) reads 00h, and the time registers read seconds 00 with the stop flag clear, minutes 00, hours 00, day 01, date 01, month 01 and year 00.
- R2: While running, seconds advance once every PRESCALE_DIV cycles with osc_en_i high. Seconds 59 wrap to 00 and carry into minutes, minutes 59 wrap to 00 and carry into hours, and hours 23 wrap to 00. That last carry advances day of week, where 7 wraps to 1, and date.
- R3: Date wraps to 01 and advances the month after 30 in months 04, 06, 09 and 11, after 29 in month 02 of a year divisible by 4, after 28 in month 02 of other years, and after 31 in all other months. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R4: Register map: offset 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. Control bit 7 is the load-halt bit. While it is 1, the visible time registers stop following the counters, and writes to offsets 1 to 7 are stored there and read back.
- R5: Writing control bit 7 as 0 while it is 1 loads every visible time value into the counters at that write's clock edge and clears the divider, so the next seconds increment comes exactly PRESCALE_DIV enabled cycles later.
- R6: Writes to offsets 1 to 7 while control bit 7 is 0 leave the time values unchanged.
- R7: Control bit 6 is the read-halt bit. While it is 1, reads return the values held at the edge where it was set, and control reads back 40h. The counters keep running, and the advanced time is visible once the bit is cleared.
- R8: Seconds register bit 7 is the stop flag. It is written on every write to offset 1, regardless of control bit 7. While it is 1, no counter advances, and it reads back as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | Oscillator enable pulse feeding the divider |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |

## Verification
The hardest case to reach is showing that a commit restarts the divider. The divider normally wraps on its own, so a missing clear goes unseen unless the divider is left part-way through its count when the load happens. The stimulus gets there by stopping the oscillator at a known divider phase, starting it again through the seconds register while loads are halted, and waiting an extra cycle before the commit. It then reads seconds on the two cycles that bracket the expected first increment. Calendar rollovers are reached by loading the last second of a chosen day with the stop flag set, committing, and releasing the oscillator for exactly one second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;

  localparam int unsigned CTRL_LOAD_BIT = 7;
  localparam int unsigned CTRL_SNAP_BIT = 6;
  localparam int unsigned SEC_STOP_BIT  = 7;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 3'd0,
    REG_SEC   = 3'd1,
    REG_MIN   = 3'd2,
    REG_HOUR  = 3'd3,
    REG_DAY   = 3'd4,
    REG_DATE  = 3'd5,
    REG_MONTH = 3'd6,
    REG_YEAR  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [2:0] day;
    logic [5:0] date;
    logic [4:0] month;
    logic [7:0] year;
  } rtc_time_t;

  localparam rtc_time_t TIME_RESET = '{
    sec: 7'h00, min: 7'h00, hour: 6'h00, day: 3'd1,
    date: 6'h01, month: 5'h01, year: 8'h00
  };

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [5:0] month_last_date(input logic [4:0] month,
                                                 input logic [7:0] year);
    logic [6:0] yb;
    yb = bcd_to_bin(year);
    case (month)
      5'h02:                      return (yb[1:0] == 2'b00) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  // {carry, next}; anything at or past 'last' wraps to 'first'
  function automatic logic [8:0] bcd_next(input logic [7:0] v,
                                          input logic [7:0] last,
                                          input logic [7:0] first);
    if (v >= last)            return {1'b1, first};
    else if (v[3:0] >= 4'h9)  return {1'b0, v[7:4] + 4'h1, 4'h0};
    else                      return {1'b0, v[7:4], v[3:0] + 4'h1};
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i & osc_en_i & (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (run_i && osc_en_i) cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t time_o
);
  rtc_time_t  time_q, time_d;
  logic [8:0] sec_n, min_n, hour_n, date_n, month_n, year_n;
  logic       unused_bits;

  assign unused_bits = ^{sec_n[7], min_n[7], hour_n[7:6], date_n[7:6], month_n[7:5]};

  always_comb begin
    sec_n   = bcd_next({1'b0, time_q.sec}, 8'h59, 8'h00);
    min_n   = bcd_next({1'b0, time_q.min}, 8'h59, 8'h00);
    hour_n  = bcd_next({2'b0, time_q.hour}, 8'h23, 8'h00);
    date_n  = bcd_next({2'b0, time_q.date},
                       {2'b0, month_last_date(time_q.month, time_q.year)}, 8'h01);
    month_n = bcd_next({3'b0, time_q.month}, 8'h12, 8'h01);
    year_n  = bcd_next(time_q.year, 8'h99, 8'h00);

    time_d = time_q;
    if (load_i) begin
      time_d = load_val_i;
    end else if (tick_i) begin
      time_d.sec = sec_n[6:0];
      if (sec_n[8]) begin
        time_d.min = min_n[6:0];
        if (min_n[8]) begin
          time_d.hour = hour_n[5:0];
          if (hour_n[8]) begin
            time_d.day  = (time_q.day >= 3'd7) ? 3'd1 : time_q.day + 3'd1;
            time_d.date = date_n[5:0];
            if (date_n[8]) begin
              time_d.month = month_n[4:0];
              if (month_n[8]) time_d.year = year_n[7:0];
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= TIME_RESET;
    else         time_q <= time_d;
  end

  assign time_o = time_q;

  // R2
  sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && time_q.sec == 7'h59) |=> (time_q.sec == 7'h00));

  // R2
  min_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && time_q.sec < 7'h59) |=> $stable(time_q.min));
endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  rtc_time_t         live_i,
  output rtc_time_t         hold_o,
  output logic              stop_o,
  output logic              commit_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e  sel;
  logic      load_q, snap_q, stop_q;
  logic      ctrl_wr, time_wr, freeze;
  rtc_time_t hold_q;

  assign sel      = reg_sel_e'(addr_i);
  assign ctrl_wr  = wr_i && (sel == REG_CTRL);
  assign time_wr  = wr_i && (sel != REG_CTRL);
  assign freeze   = load_q | snap_q;
  assign commit_o = ctrl_wr & load_q & ~wdata_i[CTRL_LOAD_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      snap_q <= 1'b0;
    end else if (ctrl_wr) begin
      load_q <= wdata_i[CTRL_LOAD_BIT];
      snap_q <= wdata_i[CTRL_SNAP_BIT];
    end
  end

  // stop flag takes every seconds write, halt bits or not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       stop_q <= 1'b0;
    else if (wr_i && sel == REG_SEC)   stop_q <= wdata_i[SEC_STOP_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= TIME_RESET;
    end else if (!freeze) begin
      hold_q <= live_i;
    end else if (time_wr && load_q) begin
      case (sel)
        REG_SEC:   hold_q.sec   <= wdata_i[6:0];
        REG_MIN:   hold_q.min   <= wdata_i[6:0];
        REG_HOUR:  hold_q.hour  <= wdata_i[5:0];
        REG_DAY:   hold_q.day   <= wdata_i[2:0];
        REG_DATE:  hold_q.date  <= wdata_i[5:0];
        REG_MONTH: hold_q.month <= wdata_i[4:0];
        REG_YEAR:  hold_q.year  <= wdata_i;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      REG_CTRL:  rdata_o = {load_q, snap_q, 6'b0};
      REG_SEC:   rdata_o = {stop_q, hold_q.sec};
      REG_MIN:   rdata_o = {1'b0, hold_q.min};
      REG_HOUR:  rdata_o = {2'b0, hold_q.hour};
      REG_DAY:   rdata_o = {5'b0, hold_q.day};
      REG_DATE:  rdata_o = {2'b0, hold_q.date};
      REG_MONTH: rdata_o = {3'b0, hold_q.month};
      REG_YEAR:  rdata_o = hold_q.year;
      default:   rdata_o = '0;
    endcase
  end

  assign hold_o = hold_q;
  assign stop_o = stop_q;

  // R4
  frozen_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze && !time_wr) |=> $stable(hold_q));

  // R6
  open_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_wr && !freeze) |=> (hold_q == $past(live_i)));
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned PRESCALE_DIV = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  rtc_time_t live, hold;
  logic      stop, commit, sec_tick;

  rtc_reg_bank i_reg_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .live_i   (live),
    .hold_o   (hold),
    .stop_o   (stop),
    .commit_o (commit),
    .rdata_o  (rdata_o)
  );

  rtc_prescaler #(.DIV(PRESCALE_DIV)) i_prescaler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .osc_en_i (osc_en_i),
    .run_i    (~stop),
    .clear_i  (commit),
    .tick_o   (sec_tick)
  );

  rtc_time_chain i_time_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (sec_tick),
    .load_i     (commit),
    .load_val_i (hold),
    .time_o     (live)
  );

  // R5
  commit_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (live == $past(hold)));

  // R8
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !commit) |=> $stable(live));
endmodule

// File: tb/test_rtc_core.sv
module test_rtc_core;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  localparam logic [2:0] A_CTRL = 3'd0, A_SEC = 3'd1, A_MIN = 3'd2, A_HOUR = 3'd3,
                         A_DAY = 3'd4, A_DATE = 3'd5, A_MONTH = 3'd6, A_YEAR = 3'd7;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       osc_en_i = 1'b1;
  logic       wr_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rtc_core #(.PRESCALE_DIV(DIV)) i_rtc_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .osc_en_i (osc_en_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o)
  );

  int         n_cmp = 0;
  int         n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] adr_q[$];
  event       sample_ev;
  bit         done = 1'b0;

  // driver: queue expectation, sample off the edge
  task automatic check_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk_i);
    addr_i = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    adr_q.push_back(a);
    #1;
    -> sample_ev;
  endtask

  // monitor
  initial forever begin
    logic [7:0] e;
    string      t;
    logic [2:0] a;
    @(sample_ev);
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = adr_q.pop_front();
      n_cmp++;
      if (rdata_o !== e) begin
        n_bad++;
        $display("FAIL %s offset %0d actual %02h expected %02h", t, a, rdata_o, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // load 23:59:59 on a given day with stop set, commit, run exactly one second, stop
  task automatic roll_once(input logic [7:0] day, input logic [7:0] date,
                           input logic [7:0] month, input logic [7:0] year);
    wr(A_CTRL, 8'h80);
    wr(A_SEC, 8'hD9);
    wr(A_MIN, 8'h59);
    wr(A_HOUR, 8'h23);
    wr(A_DAY, day);
    wr(A_DATE, date);
    wr(A_MONTH, month);
    wr(A_YEAR, year);
    wr(A_CTRL, 8'h00);
    wr(A_SEC, 8'h00);
    idle(4);
    wr(A_SEC, 8'h80);
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;

    check_rd(A_SEC,   8'h00, "R1 sec");
    check_rd(A_CTRL,  8'h00, "R1 ctrl");
    check_rd(A_MIN,   8'h00, "R1 min");
    check_rd(A_HOUR,  8'h00, "R1 hour");
    check_rd(A_DAY,   8'h01, "R1 day");
    check_rd(A_DATE,  8'h01, "R1 date");
    check_rd(A_MONTH, 8'h01, "R1 month");
    check_rd(A_YEAR,  8'h00, "R1 year");

    wr(A_MIN, 8'h45);
    wr(A_DATE, 8'h17);
    check_rd(A_MIN,  8'h00, "R6 min write without halt");
    check_rd(A_DATE, 8'h01, "R6 date write without halt");

    wr(A_CTRL, 8'h80);
    wr(A_SEC, 8'h90);
    wr(A_MIN, 8'h59);
    wr(A_HOUR, 8'h23);
    wr(A_DAY, 8'h07);
    wr(A_DATE, 8'h28);
    wr(A_MONTH, 8'h02);
    wr(A_YEAR, 8'h23);
    idle(10);
    check_rd(A_CTRL, 8'h80, "R4 ctrl");
    check_rd(A_SEC,  8'h90, "R4 sec held");
    check_rd(A_HOUR, 8'h23, "R4 hour held");
    check_rd(A_DATE, 8'h28, "R4 date held");
    wr(A_CTRL, 8'h00);
    idle(20);
    check_rd(A_SEC, 8'h90, "R8 stopped sec");
    check_rd(A_MIN, 8'h59, "R5 committed min");

    roll_once(8'h07, 8'h28, 8'h02, 8'h23);
    check_rd(A_SEC,   8'h80, "R2 sec wrap");
    check_rd(A_MIN,   8'h00, "R2 min wrap");
    check_rd(A_HOUR,  8'h00, "R2 hour wrap");
    check_rd(A_DAY,   8'h01, "R2 day wrap");
    check_rd(A_DATE,  8'h01, "R3 feb28 plain year");
    check_rd(A_MONTH, 8'h03, "R3 feb28 plain year");
    check_rd(A_YEAR,  8'h23, "R3 year kept");

    roll_once(8'h03, 8'h28, 8'h02, 8'h24);
    check_rd(A_DAY,   8'h04, "R2 day advance");
    check_rd(A_DATE,  8'h29, "R3 leap feb28");
    check_rd(A_MONTH, 8'h02, "R3 leap feb28");

    roll_once(8'h04, 8'h29, 8'h02, 8'h24);
    check_rd(A_DATE,  8'h01, "R3 leap feb29");
    check_rd(A_MONTH, 8'h03, "R3 leap feb29");

    roll_once(8'h02, 8'h30, 8'h04, 8'h23);
    check_rd(A_DATE,  8'h01, "R3 apr30");
    check_rd(A_MONTH, 8'h05, "R3 apr30");

    roll_once(8'h05, 8'h30, 8'h01, 8'h23);
    check_rd(A_DATE,  8'h31, "R3 jan30");
    check_rd(A_MONTH, 8'h01, "R3 jan30");

    roll_once(8'h06, 8'h31, 8'h12, 8'h99);
    check_rd(A_DAY,   8'h07, "R2 day six to seven");
    check_rd(A_DATE,  8'h01, "R3 dec31");
    check_rd(A_MONTH, 8'h01, "R3 dec31");
    check_rd(A_YEAR,  8'h00, "R3 year 99 wrap");

    // divider parked mid-count; restart while halted, one spare cycle, then commit
    wr(A_CTRL, 8'h80);
    wr(A_SEC, 8'h05);
    idle(1);
    wr(A_CTRL, 8'h00);
    idle(3);
    check_rd(A_SEC, 8'h05, "R5 no early increment");
    check_rd(A_SEC, 8'h06, "R5 first increment");

    wr(A_CTRL, 8'h40);
    check_rd(A_CTRL, 8'h40, "R7 ctrl");
    idle(11);
    check_rd(A_SEC, 8'h06, "R7 snapshot");
    wr(A_CTRL, 8'h00);
    idle(2);
    check_rd(A_SEC, 8'h11, "R7 counters ran");

    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule